// File: doc/BRIEF.md
# Instruction Block Unpacker with In-Block Constants

This block takes instruction fetch blocks of 256 bits, each divided into eight 32-bit slots, and streams the executable slots one per cycle to a downstream consumer over a valid/ready handshake. A block may open with a header word. The header's count field reserves slots at the tail of the block for constant data. Those reserved slots, and the header word, are never streamed as instructions.

Alongside the instruction stream the block serves operand constants. A 6-bit pointer selects a byte offset (lower five bits) within either the block now being unpacked or, when the upper bit is set, a retained copy of the block accepted before it. The constant is read little-endian as 1, 2, 4 or 8 bytes and is returned zero-extended to 64 bits. This read is combinational, and a read of the retained copy never issues a memory fetch: it is served from a holding register that is refreshed each time a block is accepted.

A fetch unit drives blocks in. An issue stage takes the slots and presents each instruction's constant pointer and size to the lookup port.

Top module: `imm_block_unpacker`

## Requirements
- R1: After reset, insValid is 0, blkReady is 1, hdrErr is 0, and every constant read reports cErr=1 with cData=0.
- R2: When blkHasHdr is 1, bits 3:0 of slot 0 (block bits 3:0) give a reserved count N. The rest of the header word is ignored. Slots 1 through 7-N are streamed in ascending order, and insSlot carries each slot's index. Slot k occupies block bits 32k+31:32k.
- R3: When blkHasHdr is 0, all eight slots 0 to 7 are streamed in ascending order.
- R4: While insValid is 1 and insReady is 0, insData and insSlot hold steady. One slot advances per cycle in which both are 1. blkReady is 0 while slots of a block remain to be streamed.
- R5: A header count above 7 is illegal. hdrErr is 1 for the single cycle after acceptance, no slot of that block is streamed, and blkReady stays 1.
- R6: With cPtr[5]=0, the constant is read from the current block at byte offset cPtr[4:0], where byte b is block bits 8b+7:8b. cSize encodes the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. The bytes are assembled little-endian and zero-extended to 64 bits.
- R7: A read whose last byte would lie past byte 31 gives cErr=1 and cData=0. A read that ends exactly at byte 31 is legal.
- R8: With cPtr[5]=1, the constant is read, using the R6 rules, from the block that was current before the most recent acceptance. Each acceptance, including that of an illegal block, moves the current block into the holding copy.
- R9: A read of the current block before any acceptance gives cErr=1 and cData=0. A read of the holding copy gives the same result until two blocks have been accepted.
- R10: A legal header whose count leaves no instruction slot (N=7) streams nothing and raises no hdrErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blkValid | input | 1 | A fetch block is offered |
| blkReady | output | 1 | The unpacker can accept a block |
| blkData | input | 256 | Fetch block, slot 0 in the low bits |
| blkHasHdr | input | 1 | Slot 0 of the offered block is a header |
| insValid | output | 1 | An instruction slot is presented |
| insReady | input | 1 | Consumer takes the presented slot |
| insData | output | 32 | Instruction word |
| insSlot | output | 3 | Index of the presented slot in its block |
| hdrErr | output | 1 | One-cycle flag for an illegal header count |
| cPtr | input | 6 | Constant pointer: bit 5 selects the holding copy, bits 4:0 give the byte offset |
| cSize | input | 2 | Constant width code |
| cData | output | 64 | Zero-extended constant |
| cErr | output | 1 | Constant read out of range or from an empty source |

## Verification
The assertions watch the handshake on every cycle. They check that a stalled slot is held, that slot indices rise by one per transfer, that intake and streaming never overlap, that an illegal header never coexists with a presented slot, and that constant results are zero on error and zero above the requested width. The behaviours that depend on content can only be shown by the directed scenarios. These are which slots are skipped for a given header count, the little-endian byte values at chosen offsets, the exact boundary of the overrun test, and the contents of the holding copy after a run of acceptances.

// File: rtl/imm_unpack_pkg.sv
package imm_unpack_pkg;
  typedef struct packed {
    logic loadBlk;
    logic advance;
  } unpack_strobe_t;

  typedef enum logic [1:0] {
    CSZ_BYTE  = 2'd0,
    CSZ_HALF  = 2'd1,
    CSZ_WORD  = 2'd2,
    CSZ_DWORD = 2'd3
  } const_size_e;
endpackage

// File: rtl/imm_unpack_ctrl.sv
module imm_unpack_ctrl
  import imm_unpack_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(N_SLOTS),
  localparam int END_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  input  logic             blkHasHdr,
  input  logic [CNT_W-1:0] hdrCnt,
  input  logic             insReady,
  output logic             blkReady,
  output logic             insValid,
  output logic [IDX_W-1:0] slotIdx,
  output logic             hdrErr,
  output unpack_strobe_t   strobe
);
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             accept;
  logic [END_W-1:0] resvCnt;
  logic [END_W-1:0] firstSlot;
  logic [END_W-1:0] endSlot;
  logic             illegal;
  logic             anyIns;

  assign blkReady = !busy;
  assign accept   = blkValid && !busy;
  assign insValid = busy;
  assign slotIdx  = idx;

  always_comb begin
    resvCnt   = blkHasHdr ? END_W'(hdrCnt) : '0;
    firstSlot = blkHasHdr ? END_W'(1) : '0;
    illegal   = blkHasHdr && (resvCnt > END_W'(N_SLOTS - 1));
    endSlot   = END_W'(N_SLOTS) - resvCnt;
    anyIns    = !illegal && (firstSlot < endSlot);
  end

  always_comb begin
    strobe.loadBlk = accept;
    strobe.advance = busy && insReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      idx     <= '0;
      lastIdx <= '0;
      hdrErr  <= 1'b0;
    end else if (accept) begin
      busy    <= anyIns;
      idx     <= IDX_W'(firstSlot);
      lastIdx <= IDX_W'(endSlot - END_W'(1));
      hdrErr  <= illegal;
    end else begin
      hdrErr <= 1'b0;
      if (busy && insReady) begin
        if (idx == lastIdx) busy <= 1'b0;
        else idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/imm_const_rd.sv
module imm_const_rd #(
  parameter int BLK_W = 256,
  parameter int CONST_W = 64,
  localparam int N_BYTES = BLK_W / 8,
  localparam int OFF_W = $clog2(N_BYTES),
  localparam int C_BYTES = CONST_W / 8,
  localparam int CNT_W = OFF_W + 2
) (
  input  logic [BLK_W-1:0]   srcBlk,
  input  logic               srcOk,
  input  logic [OFF_W-1:0]   byteOff,
  input  logic [1:0]         sizeCode,
  output logic [CONST_W-1:0] value,
  output logic               fault
);
  logic [CNT_W-1:0]   numBytes;
  logic [CNT_W-1:0]   endByte;
  logic               overrun;
  logic [BLK_W-1:0]   shifted;
  logic [CONST_W-1:0] laneMask;

  assign numBytes = CNT_W'(1) << sizeCode;
  assign endByte  = CNT_W'(byteOff) + numBytes;
  assign overrun  = endByte > CNT_W'(N_BYTES);
  assign shifted  = srcBlk >> {byteOff, 3'b000};

  for (genvar b = 0; b < C_BYTES; b++) begin : g_lane
    assign laneMask[8*b +: 8] = (CNT_W'(b) < numBytes) ? 8'hFF : 8'h00;
  end

  assign fault = !srcOk || overrun;
  assign value = fault ? '0 : (shifted[CONST_W-1:0] & laneMask);
endmodule

// File: rtl/imm_unpack_dp.sv
module imm_unpack_dp
  import imm_unpack_pkg::*;
#(
  parameter int BLK_W = 256,
  parameter int SLOT_W = 32,
  parameter int CONST_W = 64,
  localparam int N_SLOTS = BLK_W / SLOT_W,
  localparam int IDX_W = $clog2(N_SLOTS),
  localparam int OFF_W = $clog2(BLK_W / 8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  unpack_strobe_t     strobe,
  input  logic [BLK_W-1:0]   blkData,
  input  logic [IDX_W-1:0]   slotIdx,
  output logic [SLOT_W-1:0]  insData,
  input  logic [OFF_W:0]     cPtr,
  input  logic [1:0]         cSize,
  output logic [CONST_W-1:0] cData,
  output logic               cErr
);
  logic [BLK_W-1:0] curBlk;
  logic [BLK_W-1:0] prevBlk;
  logic             curOk;
  logic             prevOk;
  logic [SLOT_W-1:0] slotWords [N_SLOTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBlk  <= '0;
      prevBlk <= '0;
      curOk   <= 1'b0;
      prevOk  <= 1'b0;
    end else if (strobe.loadBlk) begin
      curBlk  <= blkData;
      prevBlk <= curBlk;
      curOk   <= 1'b1;
      prevOk  <= curOk;
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    assign slotWords[s] = curBlk[SLOT_W*s +: SLOT_W];
  end

  assign insData = slotWords[slotIdx];

  logic             usePrev;
  logic [BLK_W-1:0] srcBlk;
  logic             srcOk;

  assign usePrev = cPtr[OFF_W];
  assign srcBlk  = usePrev ? prevBlk : curBlk;
  assign srcOk   = usePrev ? prevOk : curOk;

  imm_const_rd #(.BLK_W(BLK_W), .CONST_W(CONST_W)) u_rd (
    .srcBlk  (srcBlk),
    .srcOk   (srcOk),
    .byteOff (cPtr[OFF_W-1:0]),
    .sizeCode(cSize),
    .value   (cData),
    .fault   (cErr)
  );
endmodule

// File: rtl/imm_block_unpacker.sv
module imm_block_unpacker
  import imm_unpack_pkg::*;
#(
  parameter int BLK_W = 256,
  parameter int SLOT_W = 32,
  parameter int CONST_W = 64,
  parameter int CNT_W = 4,
  localparam int N_SLOTS = BLK_W / SLOT_W,
  localparam int IDX_W = $clog2(N_SLOTS),
  localparam int OFF_W = $clog2(BLK_W / 8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               blkValid,
  output logic               blkReady,
  input  logic [BLK_W-1:0]   blkData,
  input  logic               blkHasHdr,
  output logic               insValid,
  input  logic               insReady,
  output logic [SLOT_W-1:0]  insData,
  output logic [IDX_W-1:0]   insSlot,
  output logic               hdrErr,
  input  logic [OFF_W:0]     cPtr,
  input  logic [1:0]         cSize,
  output logic [CONST_W-1:0] cData,
  output logic               cErr
);
  unpack_strobe_t   strobe;
  logic [IDX_W-1:0] slotIdx;

  imm_unpack_ctrl #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .blkValid (blkValid),
    .blkHasHdr(blkHasHdr),
    .hdrCnt   (blkData[CNT_W-1:0]),
    .insReady (insReady),
    .blkReady (blkReady),
    .insValid (insValid),
    .slotIdx  (slotIdx),
    .hdrErr   (hdrErr),
    .strobe   (strobe)
  );

  imm_unpack_dp #(.BLK_W(BLK_W), .SLOT_W(SLOT_W), .CONST_W(CONST_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .blkData(blkData),
    .slotIdx(slotIdx),
    .insData(insData),
    .cPtr   (cPtr),
    .cSize  (cSize),
    .cData  (cData),
    .cErr   (cErr)
  );

  assign insSlot = slotIdx;
endmodule

// File: rtl/imm_unpacker_chk.sv
module imm_unpacker_chk #(
  parameter int SLOT_W = 32,
  parameter int IDX_W = 3,
  parameter int CONST_W = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               blkReady,
  input logic               insValid,
  input logic               insReady,
  input logic [SLOT_W-1:0]  insData,
  input logic [IDX_W-1:0]   insSlot,
  input logic               hdrErr,
  input logic [1:0]         cSize,
  input logic [CONST_W-1:0] cData,
  input logic               cErr
);
  // R4: a stalled slot stays put
  a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    insValid && !insReady |=> insValid && $stable(insData) && $stable(insSlot));

  // R4: no intake while a block is being streamed
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(insValid && blkReady));

  // R2 / R3: slot indices rise by one per transfer
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rstN)
    insValid && insReady |=> !insValid || (insSlot == IDX_W'($past(insSlot) + 1)));

  // R5: an illegal header never shows a slot
  a_r5_no_emit: assert property (@(posedge clk) disable iff (!rstN)
    hdrErr |-> !insValid && blkReady);

  // R7: error result is zero
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    cErr |-> cData == '0);

  // R6: zero extension above requested width
  a_r6_zext: assert property (@(posedge clk) disable iff (!rstN)
    (cSize == 2'd0 |-> cData[CONST_W-1:8] == '0) and
    (cSize == 2'd1 |-> cData[CONST_W-1:16] == '0) and
    (cSize == 2'd2 |-> cData[CONST_W-1:32] == '0));
endmodule

bind imm_block_unpacker imm_unpacker_chk #(.SLOT_W(SLOT_W), .IDX_W(IDX_W), .CONST_W(CONST_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .blkReady(blkReady),
  .insValid(insValid),
  .insReady(insReady),
  .insData (insData),
  .insSlot (insSlot),
  .hdrErr  (hdrErr),
  .cSize   (cSize),
  .cData   (cData),
  .cErr    (cErr)
);

// File: tb/test_imm_block_unpacker.sv
module test_imm_block_unpacker;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         blkValid = 1'b0;
  logic         blkReady;
  logic [255:0] blkData = '0;
  logic         blkHasHdr = 1'b0;
  logic         insValid;
  logic         insReady = 1'b1;
  logic [31:0]  insData;
  logic [2:0]   insSlot;
  logic         hdrErr;
  logic [5:0]   cPtr = '0;
  logic [1:0]   cSize = '0;
  logic [63:0]  cData;
  logic         cErr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  imm_block_unpacker i_imm_block_unpacker (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkReady(blkReady),
    .blkData(blkData), .blkHasHdr(blkHasHdr), .insValid(insValid),
    .insReady(insReady), .insData(insData), .insSlot(insSlot), .hdrErr(hdrErr),
    .cPtr(cPtr), .cSize(cSize), .cData(cData), .cErr(cErr)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mkBlk(input int seed, input logic hdr, input int cnt);
    logic [255:0] b;
    for (int i = 0; i < 8; i++)
      b[32*i +: 32] = {8'(seed), 8'(i), 8'h5A ^ 8'(i * 7), 8'(seed * 13 + i)};
    if (hdr) b[31:0] = {24'hAB12C0, 4'h0, 4'(cnt)};
    return b;
  endfunction

  function automatic logic [63:0] expConst(input logic [255:0] b, input int off, input int sz);
    logic [63:0] v = '0;
    int n = 1 << sz;
    for (int i = 0; i < n; i++) v[8*i +: 8] = b[8*(off + i) +: 8];
    return v;
  endfunction

  task automatic sendBlk(input logic [255:0] b, input logic hdr);
    while (!blkReady) begin @(posedge clk); @(negedge clk); end
    blkData = b; blkHasHdr = hdr; blkValid = 1'b1;
    @(posedge clk); @(negedge clk);
    blkValid = 1'b0;
  endtask

  task automatic collect(input logic [255:0] b, input int first, input int last, input int stallAt, input string req);
    for (int k = first; k <= last; k++) begin
      if (k == stallAt) begin
        insReady = 1'b0;
        for (int s = 0; s < 2; s++) begin
          @(posedge clk); @(negedge clk);
          check(insValid && insSlot == 3'(k) && insData == b[32*k +: 32], "R4 stall hold",
                {32'(insSlot), insData}, {32'(k), b[32*k +: 32]});
        end
        insReady = 1'b1;
      end
      check(insValid && insData == b[32*k +: 32], req, {31'd0, insValid, insData}, {32'd1, b[32*k +: 32]});
      check(insSlot == 3'(k), req, 64'(insSlot), 64'(k));
      check(!blkReady, "R4 intake blocked", 64'(blkReady), 64'd0);
      @(posedge clk); @(negedge clk);
    end
    check(!insValid && blkReady, "R4 stream end", {insValid, blkReady}, 2'b01);
  endtask

  task automatic rdConst(input logic prev, input int off, input int sz, input logic expErr,
                         input logic [63:0] expVal, input string req);
    cPtr = {prev, 5'(off)}; cSize = 2'(sz);
    #1;
    check(cErr == expErr && cData == expVal, req, cData, expVal);
  endtask

  task automatic tReset();
    check(!insValid && blkReady && !hdrErr, "R1 reset outputs", {insValid, blkReady, hdrErr}, 3'b010);
    rdConst(1'b0, 0, 3, 1'b1, 64'd0, "R9 current before any block");
    rdConst(1'b1, 0, 0, 1'b1, 64'd0, "R1 holding copy empty");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] blkA, blkB, blkC, blkD, blkE;
    blkA = mkBlk(1, 1'b0, 0);
    blkB = mkBlk(2, 1'b1, 3);
    blkC = mkBlk(3, 1'b1, 9);
    blkD = mkBlk(4, 1'b1, 7);
    blkE = mkBlk(5, 1'b1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();

    // R3: no header, all slots
    sendBlk(blkA, 1'b0);
    collect(blkA, 0, 7, -1, "R3 headerless slot");
    rdConst(1'b0, 5, 1, 1'b0, expConst(blkA, 5, 1), "R6 half at odd offset");
    rdConst(1'b1, 0, 2, 1'b1, 64'd0, "R9 holding copy after one block");

    // R2: header reserves three, slots 1..4, stall on slot 2
    sendBlk(blkB, 1'b1);
    collect(blkB, 1, 4, 2, "R2 header skip slot");
    rdConst(1'b0, 28, 2, 1'b0, expConst(blkB, 28, 2), "R7 word ending at byte 31");
    rdConst(1'b0, 31, 0, 1'b0, expConst(blkB, 31, 0), "R7 last byte");
    rdConst(1'b0, 24, 3, 1'b0, expConst(blkB, 24, 3), "R6 dword tail");
    rdConst(1'b0, 30, 2, 1'b1, 64'd0, "R7 word overrun");
    rdConst(1'b0, 25, 3, 1'b1, 64'd0, "R7 dword overrun");
    rdConst(1'b1, 8, 3, 1'b0, expConst(blkA, 8, 3), "R8 holding copy dword");
    rdConst(1'b1, 3, 0, 1'b0, expConst(blkA, 3, 0), "R8 holding copy byte");

    // R5: illegal count
    sendBlk(blkC, 1'b1);
    check(hdrErr && !insValid && blkReady, "R5 illegal header", {hdrErr, insValid, blkReady}, 3'b101);
    @(posedge clk); @(negedge clk);
    check(!hdrErr && !insValid, "R5 flag one cycle", {hdrErr, insValid}, 2'b00);
    rdConst(1'b1, 4, 2, 1'b0, expConst(blkB, 4, 2), "R8 copy after illegal block");

    // R10: count 7 leaves nothing
    sendBlk(blkD, 1'b1);
    check(!hdrErr && !insValid && blkReady, "R10 empty block", {hdrErr, insValid, blkReady}, 3'b001);
    rdConst(1'b0, 4, 2, 1'b0, expConst(blkD, 4, 2), "R6 word read of empty block");
    rdConst(1'b1, 0, 1, 1'b0, expConst(blkC, 0, 1), "R8 copy holds illegal block");

    // R2: header with zero reserved
    sendBlk(blkE, 1'b1);
    collect(blkE, 1, 7, 6, "R2 header zero reserve");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule